// File: doc/BRIEF.md
# Differential-Transformer Position Demodulator

This block drives and reads a differential-transformer position sensor. It outputs a digital excitation carrier at one quarter of the converter sample rate, taken from a four-entry sine table. It takes back interleaved converter samples of two channels: the primary drive voltage and the conditioned secondary voltage. It returns one signed displacement word for each carrier cycle.

Each carrier cycle has four sample slots. For each channel the block folds the four samples into an in-phase and a quadrature difference, which keeps only the carrier-frequency component. It projects the secondary vector onto the primary vector and divides by the squared primary magnitude. The result is a signed amplitude ratio, and its sign follows the relative phase of the two channels (near 0° or near 180°). A bit-serial divider produces the ratio. The ratio is then multiplied by a calibration length to give the displacement. If the primary magnitude is too small, the block raises an excitation-fault flag and keeps the last good displacement.

Top module: `xfmr_pos_demod`

## Requirements
- R1: `dac_o` follows the sequence +EXC_AMP, 0, −EXC_AMP, 0 (cosine phase). It starts at +EXC_AMP after reset and moves one entry each time a sample slot completes.
- R2: A sample with `smp_sec`=0 is a primary sample and one with `smp_sec`=1 is a secondary sample. Each slot takes one primary sample and then one secondary sample. Only the secondary sample completes the slot, so a primary sample leaves `dac_o` unchanged.
- R3: Let x0..x3 be one channel's samples in slots 0..3. Then I = x0−x2 and Q = x1−x3. With P = Ip·Is + Qp·Qs and M = Ip² + Qp² (p = primary, s = secondary), the ratio magnitude is floor(|P|·4096/M), and the ratio takes the sign of P. `disp_o` = ratio × `cal_len`. The value of `cal_len` is taken when the slot-3 secondary sample arrives.
- R4: The displacement is positive when the secondary is near 0° from the primary and negative when it is near 180°, including when the phase deviates by several degrees.
- R5: Scaling both channels by the same integer factor leaves `disp_o` unchanged.
- R6: A constant offset and a component at half the sample rate, added to either channel, do not change `disp_o`.
- R7: If M < `min_mag`, `exc_fault` goes high, `disp_o` keeps its previous value and `disp_vld` does not pulse. The next cycle that passes the check clears `exc_fault`.
- R8: `disp_vld` is a one-cycle pulse, given once for each completed carrier cycle that passes the check, within 60 clock cycles of the closing secondary sample.
- R9: Synchronous reset returns the table to slot 0 and clears both channels' accumulators. After reset, no `disp_vld` appears until a full four-slot cycle has been collected, and samples taken before the reset do not affect later results.
- R10: A ratio magnitude above 32767 saturates to 32767 before it is scaled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Converter sample strobe |
| smp_sec | input | 1 | Channel of the sample: 0 primary, 1 secondary |
| smp_data | input | 14 | Two's-complement converter sample |
| cal_len | input | 16 | Signed calibration length |
| min_mag | input | 31 | Minimum accepted squared primary magnitude |
| dac_o | output | 14 | Two's-complement excitation word to the DAC |
| disp_o | output | 32 | Signed displacement |
| disp_vld | output | 1 | One-cycle strobe for a new displacement |
| exc_fault | output | 1 | Primary magnitude below minimum; output held |

## Verification
The hardest situation to reach is an excitation fault that arrives after a valid result. Only then can the bench show that the held value really is the earlier displacement, and that the flag clears again without a stray strobe. The stimulus reaches it with a directed cycle of very small primary amplitude, placed between two normal cycles. A reset in the middle of a cycle, followed by a fresh cycle, shows that no partial sum leaks through. The random cycles add an offset and a half-rate term to every channel, so harmonic rejection is exercised on every result rather than only in one directed case.

// File: rtl/xfmr_pkg.sv
package xfmr_pkg;

    localparam int SMP_W  = 14;
    localparam int FRAC_W = 12;
    localparam int RAT_W  = 16;
    localparam int CAL_W  = 16;
    localparam int IQ_W   = SMP_W + 1;
    localparam int PROD_W = 2 * IQ_W + 1;
    localparam int DIVN_W = PROD_W + FRAC_W;
    localparam int DISP_W = RAT_W + CAL_W;

    typedef logic [1:0] phase_t;

    typedef struct packed {
        logic signed [IQ_W-1:0] i;
        logic signed [IQ_W-1:0] q;
    } iq_t;

    function automatic logic signed [SMP_W-1:0] carrier_val(
        input phase_t p, input logic signed [SMP_W-1:0] amp);
        case (p)
            2'd0:    carrier_val = amp;
            2'd2:    carrier_val = -amp;
            default: carrier_val = '0;
        endcase
    endfunction

endpackage

// File: rtl/xfmr_carrier.sv
module xfmr_carrier
    import xfmr_pkg::*;
#(
    parameter logic signed [SMP_W-1:0] AMP = 14'sd6000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step,
    output phase_t                  phase_o,
    output logic signed [SMP_W-1:0] dac_o
);
    phase_t phase_q;

    always_ff @(posedge clk) begin
        if (rst)       phase_q <= '0;
        else if (step) phase_q <= phase_q + 2'd1;
    end

    assign phase_o = phase_q;
    assign dac_o   = carrier_val(phase_q, AMP);

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(step)) |-> $stable(phase_q)); // R2
    AST_ODD_ZERO: assert property (@(posedge clk) disable iff (rst)
        phase_q[0] |-> (dac_o == '0)); // R1
endmodule

// File: rtl/xfmr_iq.sv
module xfmr_iq
    import xfmr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  phase_t                  phase,
    input  logic signed [SMP_W-1:0] data,
    input  logic                    close,
    output iq_t                     iq_o
);
    iq_t acc_q, nxt, out_q;
    logic signed [IQ_W-1:0] xs;

    assign xs = IQ_W'(data);

    always_comb begin
        nxt = acc_q;
        case (phase)
            2'd0: nxt.i = acc_q.i + xs;
            2'd1: nxt.q = acc_q.q + xs;
            2'd2: nxt.i = acc_q.i - xs;
            default: nxt.q = acc_q.q - xs;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            out_q <= '0;
        end else if (close) begin
            out_q <= en ? nxt : acc_q;
            acc_q <= '0;
        end else if (en) begin
            acc_q <= nxt;
        end
    end

    assign iq_o = out_q;

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(close) |-> (acc_q == '0)); // R9
endmodule

// File: rtl/xfmr_div.sv
module xfmr_div #(
    parameter int N_W = 43,
    parameter int D_W = 31
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N_W-1:0] num,
    input  logic [D_W-1:0] den,
    output logic           busy,
    output logic           done,
    output logic [N_W-1:0] quot
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [D_W-1:0]   rem_q, den_q;
    logic [N_W-1:0]   dvd_q, quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, done_q;
    logic [D_W:0]     trial;
    logic             fits;

    assign trial = {rem_q, dvd_q[N_W-1]};
    assign fits  = (trial >= {1'b0, den_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0; den_q <= '0; dvd_q <= '0; quo_q <= '0;
            cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                rem_q  <= '0;
                den_q  <= den;
                dvd_q  <= num;
                quo_q  <= '0;
                cnt_q  <= CNT_W'(N_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= fits ? D_W'(trial - {1'b0, den_q}) : D_W'(trial);
                dvd_q <= {dvd_q[N_W-2:0], 1'b0};
                quo_q <= {quo_q[N_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quot = quo_q;

    logic [CNT_W:0] run_len;
    always_ff @(posedge clk) begin
        if (rst || !busy_q) run_len <= '0;
        else                run_len <= run_len + 1'b1;
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (run_len < (CNT_W+1)'(N_W))); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q); // R8
endmodule

// File: rtl/xfmr_pos_demod.sv
module xfmr_pos_demod
    import xfmr_pkg::*;
#(
    parameter logic signed [SMP_W-1:0] EXC_AMP = 14'sd6000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_vld,
    input  logic                     smp_sec,
    input  logic signed [SMP_W-1:0]  smp_data,
    input  logic signed [CAL_W-1:0]  cal_len,
    input  logic [PROD_W-1:0]        min_mag,
    output logic signed [SMP_W-1:0]  dac_o,
    output logic signed [DISP_W-1:0] disp_o,
    output logic                     disp_vld,
    output logic                     exc_fault
);
    localparam int RAT_MAX = 2 ** (RAT_W - 1) - 1;

    phase_t phase;
    logic   pri_en, sec_en, close;
    iq_t    iq_w [2];

    assign pri_en = smp_vld && !smp_sec;
    assign sec_en = smp_vld && smp_sec;
    assign close  = sec_en && (phase == 2'd3);

    xfmr_carrier #(.AMP(EXC_AMP)) u_carrier (
        .clk(clk), .rst(rst), .step(sec_en), .phase_o(phase), .dac_o(dac_o)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        xfmr_iq u_iq (
            .clk(clk), .rst(rst),
            .en(ch == 0 ? pri_en : sec_en),
            .phase(phase), .data(smp_data), .close(close),
            .iq_o(iq_w[ch])
        );
    end

    logic                     cyc_rdy, chk_rdy, seen_cycle, neg_q;
    logic signed [CAL_W-1:0]  cal_q;
    logic signed [PROD_W-1:0] num_q;
    logic [PROD_W-1:0]        den_q, num_abs;
    logic                     div_start, div_busy, div_done;
    logic [DIVN_W-1:0]        quot;
    logic [RAT_W-1:0]         mag;
    logic signed [RAT_W-1:0]  rat_s;

    assign num_abs   = num_q[PROD_W-1] ? PROD_W'(-num_q) : PROD_W'(num_q);
    assign div_start = chk_rdy && (den_q >= min_mag);

    xfmr_div #(.N_W(DIVN_W), .D_W(PROD_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start),
        .num({num_abs, {FRAC_W{1'b0}}}), .den(den_q),
        .busy(div_busy), .done(div_done), .quot(quot)
    );

    assign mag   = (|quot[DIVN_W-1:RAT_W-1]) ? RAT_W'(RAT_MAX) : quot[RAT_W-1:0];
    assign rat_s = neg_q ? -$signed(mag) : $signed(mag);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_rdy <= 1'b0; chk_rdy <= 1'b0; seen_cycle <= 1'b0;
            cal_q <= '0; num_q <= '0; den_q <= '0; neg_q <= 1'b0;
            disp_o <= '0; disp_vld <= 1'b0; exc_fault <= 1'b0;
        end else begin
            cyc_rdy  <= close;
            chk_rdy  <= cyc_rdy;
            disp_vld <= 1'b0;
            if (close) begin
                cal_q      <= cal_len;
                seen_cycle <= 1'b1;
            end
            if (cyc_rdy) begin
                num_q <= PROD_W'(iq_w[0].i) * PROD_W'(iq_w[1].i)
                       + PROD_W'(iq_w[0].q) * PROD_W'(iq_w[1].q);
                den_q <= PROD_W'(PROD_W'(iq_w[0].i) * PROD_W'(iq_w[0].i)
                       + PROD_W'(iq_w[0].q) * PROD_W'(iq_w[0].q));
            end
            if (chk_rdy && !div_start) exc_fault <= 1'b1;
            if (div_start)             neg_q     <= num_q[PROD_W-1];
            if (div_done) begin
                disp_o    <= rat_s * cal_q;
                disp_vld  <= 1'b1;
                exc_fault <= 1'b0;
            end
        end
    end

    AST_VLD_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        disp_vld |-> !exc_fault); // R7
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(exc_fault) |-> $stable(disp_o)); // R7
    AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (rst)
        !seen_cycle |-> !disp_vld); // R9
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        disp_vld |=> !disp_vld); // R8
    AST_SIGN: assert property (@(posedge clk) disable iff (rst)
        (disp_vld && cal_q > 0 && disp_o != 0) |-> (disp_o[DISP_W-1] == neg_q)); // R4
    AST_DIV_IDLE_AT_START: assert property (@(posedge clk) disable iff (rst)
        div_start |-> !div_busy); // R8
endmodule

// File: tb/xfmr_pos_demod_bench.sv
`timescale 1ns/1ps
module xfmr_pos_demod_bench;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_vld = 1'b0;
    logic               smp_sec = 1'b0;
    logic signed [13:0] smp_data = '0;
    logic signed [15:0] cal_len = 16'sd100;
    logic [30:0]        min_mag = 31'd1000;
    logic signed [13:0] dac_o;
    logic signed [31:0] disp_o;
    logic               disp_vld, exc_fault;

    int checks = 0, failures = 0, vld_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    xfmr_pos_demod u_xfmr_pos_demod (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_sec(smp_sec),
        .smp_data(smp_data), .cal_len(cal_len), .min_mag(min_mag),
        .dac_o(dac_o), .disp_o(disp_o), .disp_vld(disp_vld), .exc_fault(exc_fault)
    );

    always @(negedge clk) if (disp_vld) vld_cnt++;

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dac_exp(int k);
        return (k == 0) ? 6000 : (k == 2) ? -6000 : 0;
    endfunction

    function automatic int samp(int a, int b, int dc, int h, int k);
        case (k)
            0: return a + dc + h;
            1: return b + dc - h;
            2: return -a + dc + h;
            default: return -b + dc - h;
        endcase
    endfunction

    function automatic longint exp_disp(int i1, int q1, int i2, int q2, int cal);
        longint p = longint'(i1) * i2 + longint'(q1) * q2;
        longint m = longint'(i1) * i1 + longint'(q1) * q1;
        longint mg = ((p < 0 ? -p : p) <<< 12) / m;
        if (mg > 32767) mg = 32767;
        if (p < 0) mg = -mg;
        return longint'(int'(mg * cal));
    endfunction

    task automatic put(bit sec, int v);
        @(negedge clk);
        smp_vld = 1'b1; smp_sec = sec; smp_data = 14'(v);
        @(negedge clk);
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic slot(int k, int xp, int xs);
        chk("R1 dac before slot", dac_o, dac_exp(k));
        put(1'b0, xp);
        chk("R2 primary keeps dac", dac_o, dac_exp(k));
        put(1'b1, xs);
    endtask

    task automatic run_cycle(int a1, int b1, int d1, int h1, int a2, int b2, int d2, int h2);
        for (int k = 0; k < 4; k++)
            slot(k, samp(a1, b1, d1, h1, k), samp(a2, b2, d2, h2, k));
        repeat (60) @(negedge clk);
    endtask

    function automatic int rnd_amp();
        int v = 500 + int'($urandom % 2501);
        return ($urandom % 2) ? -v : v;
    endfunction

    function automatic int rnd_small();
        return int'($urandom % 1001) - 500;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int n0;
        longint d1, ref_d;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 dac after reset", dac_o, 6000);
        chk("R9 no valid after reset", disp_vld, 0);
        chk("R9 fault clear after reset", exc_fault, 0);

        // R9 partial cycle yields nothing
        n0 = vld_cnt;
        for (int k = 0; k < 3; k++) slot(k, samp(900, 0, 0, 0, k), samp(400, 0, 0, 0, k));
        repeat (60) @(negedge clk);
        chk("R9 no output on partial cycle", vld_cnt - n0, 0);

        // R9 reset mid-cycle discards partial sums
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0; @(negedge clk);
        chk("R9 dac back to slot 0", dac_o, 6000);
        n0 = vld_cnt;
        run_cycle(1000, 300, 0, 0, 700, -100, 0, 0);
        chk("R8 one strobe per cycle", vld_cnt - n0, 1);
        chk("R8 strobe is a pulse", disp_vld, 0);
        d1 = exp_disp(2000, 600, 1400, -200, 100);
        chk("R3 basic displacement", disp_o, d1);

        // R5 amplitude independence
        run_cycle(2000, 600, 0, 0, 1400, -200, 0, 0);
        chk("R5 doubled amplitude same result", disp_o, d1);

        // R6 offset and half-rate rejection
        run_cycle(1000, 300, 450, -300, 700, -100, -200, 350);
        chk("R6 offset and half-rate rejected", disp_o, d1);

        // R4 sign near 0 and near 180 with phase deviation
        run_cycle(2000, 0, 0, 0, 1500, -250, 0, 0);
        chk("R4 near 0 deg positive", disp_o > 0, 1);
        chk("R4 near 0 deg value", disp_o, exp_disp(4000, 0, 3000, -500, 100));
        run_cycle(2000, 0, 0, 0, -1500, 200, 0, 0);
        chk("R4 near 180 deg negative", disp_o < 0, 1);
        chk("R4 near 180 deg value", disp_o, exp_disp(4000, 0, -3000, 400, 100));

        // R3 negative calibration
        cal_len = -16'sd37;
        run_cycle(1200, -800, 0, 0, 300, 900, 0, 0);
        chk("R3 negative cal", disp_o, exp_disp(2400, -1600, 600, 1800, -37));

        // R10 saturation
        cal_len = 16'sd3;
        run_cycle(20, 0, 0, 0, 4000, 0, 0, 0);
        chk("R10 ratio saturates", disp_o, 32767 * 3);

        // R7 fault holds output
        cal_len = 16'sd100;
        run_cycle(1000, 300, 0, 0, 700, -100, 0, 0);
        ref_d = disp_o;
        n0 = vld_cnt;
        run_cycle(5, 5, 0, 0, 700, -100, 0, 0);
        chk("R7 fault raised", exc_fault, 1);
        chk("R7 output held", disp_o, ref_d);
        chk("R7 no strobe on fault", vld_cnt - n0, 0);
        run_cycle(1000, 300, 0, 0, -700, 100, 0, 0);
        chk("R7 fault cleared", exc_fault, 0);
        chk("R7 new value after fault", disp_o, exp_disp(2000, 600, -1400, 200, 100));

        // R3 R6 constrained random cycles
        for (int t = 0; t < 20; t++) begin
            int a1 = rnd_amp(), b1 = rnd_amp(), a2 = rnd_amp(), b2 = rnd_amp();
            int c  = int'($urandom % 2001) - 1000;
            cal_len = 16'(c);
            n0 = vld_cnt;
            run_cycle(a1, b1, rnd_small(), rnd_small(), a2, b2, rnd_small(), rnd_small());
            chk("R8 random strobe", vld_cnt - n0, 1);
            chk("R3 random displacement", disp_o,
                exp_disp(2*a1, 2*b1, 2*a2, 2*b2, c));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule